// File: doc/BRIEF.md
# Nine-Phase Dual-Carrier PWM Modulator

This block turns nine signed phase references into nine inverter leg gate bits by comparing each one against a shared triangular carrier. Before the comparison, a common offset is added to every reference. Each leg compares against either the carrier or its arithmetic negation, chosen per leg from the active sector. The references, the selection of the offset rule and the sector are all taken once per carrier period, at the carrier peak. A monitor output counts how many upper switches are on. That count is a direct image of the common-mode voltage, which sits in ten odd steps of one eighteenth of the dc link.

Three modes are available. The first is the classic min-max offset with one carrier for all legs. The second keeps the same offset but puts exactly two legs on the negated carrier, so that the inverter never produces its two all-equal states. The third clamps either the largest or the smallest reference onto a carrier rail, chosen by the sign of the ninth-harmonic cosine. In that mode it also splits the legs between the two carriers in a sliding window, so that the count of ones stays near half. The references, the sector index and the cosine sign come from the control loop. Dead time and analog measurement are outside this block.

Top module: `npwm_modulator`

## Requirements
- R1: While `rst` is high, every gate bit and the monitor count are 0. On release, the carrier starts at -FS and counts upward, where FS = 2^(REF_W-1) - 1.
- R2: The carrier steps by one each clock between -FS and +FS. Each rail value appears once per period, so the period is 4*FS clocks. With every reference at 0 in mode 0, a gate is high for 2*FS + 1 clocks of each period.
- R3: References, mode, sector and cosine sign are captured only on the clock edge at which the carrier equals +FS. Changes at any other time have no effect until the next such edge.
- R4: In mode 0 the offset is -floor((max+min)/2) over the nine captured references, and every leg uses the normal carrier. A gate bit is 1 when its offset reference is greater than or equal to its selected carrier value. The gate registers one clock after that carrier value.
- R5: In mode 1 the offset is the same as in R4. Sector code z (0..17 stands for sectors 1..18) puts leg k on the negated carrier when (z - 2k) mod 18 is 17, 0, 8 or 9. For example, z=0 selects legs 0 and 5, z=1 selects legs 1 and 5, and leg 0 is selected for z = 0, 8, 9 and 17. Codes 18..31 negate no leg.
- R6: In mode 2 the offset is FS - max when `cos9_pos_i` is 1, and -FS - min when it is 0.
- R7: In mode 2, leg k uses the negated carrier when (z - 2k) mod 18 is 9 or more. Leg 0 is normal in sectors 1..9, and each later leg shifts that window by two sectors. Codes 18..31 negate no leg.
- R8: Each offset reference is saturated to the range [-FS, +FS] instead of wrapping.
- R9: `cm_o` equals the number of ones in `gate_o` in the same cycle.
- R10: Mode code 3 behaves exactly as mode 0.
- R11: Leg k takes its reference from bits [k*REF_W +: REF_W] of `ref_flat_i` as a two's-complement value, and drives `gate_o[k]`. Leg 0 is the first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_flat_i | input | 9*REF_W | Nine signed phase references, leg k at bits [k*REF_W +: REF_W] |
| mode_i | input | 2 | 0 min-max, 1 two-leg negated carrier, 2 clamped ten-vector, 3 as 0 |
| sector_i | input | 5 | Sector code 0..17 for sectors 1..18 |
| cos9_pos_i | input | 1 | 1 when the ninth-harmonic cosine is non-negative |
| gate_o | output | 9 | Upper-switch gate bits, one per leg |
| cm_o | output | 4 | Number of gate bits that are 1 |

## Verification
A new carrier value is compared in the cycle it appears, so the matching gate bit is due one clock later. The bench therefore keeps its own carrier that starts on the same edge as reset release, and it compares every gate and count at the falling edge after the register updates. Input changes count only from the capture edge at the carrier peak. The bench model captures inputs on that same edge, so random mid-period changes check R3 cycle by cycle. Pulse-width counting over a whole period checks the carrier shape independently of the model.

// File: rtl/npwm_pkg.sv
package npwm_pkg;

    localparam int NLEG  = 9;
    localparam int NSECT = 18;
    localparam int SEC_W = 5;
    localparam int CM_W  = $clog2(NLEG + 1);

    typedef enum logic [1:0] {
        MD_CONV = 2'd0,
        MD_AZS  = 2'd1,
        MD_TLV  = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [SEC_W-1:0] sector;
        logic             cos_pos;
    } ctrl_t;

    // Two legs per sector: one advancing on odd codes, one opposite it.
    function automatic logic [NLEG-1:0] azs_mask(input logic [SEC_W-1:0] sec);
        logic [NLEG-1:0] m;
        int z, l1, l2;
        m = '0;
        if (sec < SEC_W'(NSECT)) begin
            z  = int'(sec);
            l1 = ((z + 1) / 2) % NLEG;
            l2 = ((z + 10) / 2) % NLEG;
            for (int k = 0; k < NLEG; k++)
                m[k] = (k == l1) || (k == l2);
        end
        return m;
    endfunction

    // Half-period window per leg, sliding two sectors per leg.
    function automatic logic [NLEG-1:0] tlv_mask(input logic [SEC_W-1:0] sec);
        logic [NLEG-1:0] m;
        int z, d;
        m = '0;
        if (sec < SEC_W'(NSECT)) begin
            z = int'(sec);
            for (int k = 0; k < NLEG; k++) begin
                d    = (z + NSECT - 2 * k) % NSECT;
                m[k] = (d >= NSECT / 2);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/npwm_carrier.sv
module npwm_carrier #(
    parameter int REF_W = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic signed [REF_W+1:0]   car_o,
    output logic                      peak_o
);
    localparam int SW = REF_W + 2;
    localparam logic signed [SW-1:0] FS  = SW'((1 << (REF_W - 1)) - 1);
    localparam logic signed [SW-1:0] ONE = SW'(1);

    logic up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            car_o <= -FS;
            up_q  <= 1'b1;
        end else if (up_q) begin
            car_o <= car_o + ONE;
            if (car_o == FS - ONE) up_q <= 1'b0;
        end else begin
            car_o <= car_o - ONE;
            if (car_o == -FS + ONE) up_q <= 1'b1;
        end
    end

    assign peak_o = (car_o == FS);

    // R2
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        (car_o <= FS) && (car_o >= -FS));

    // R2
    carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((car_o - $past(car_o) == ONE) || ($past(car_o) - car_o == ONE)));

endmodule

// File: rtl/npwm_offset.sv
module npwm_offset
    import npwm_pkg::*;
#(
    parameter int REF_W = 10
) (
    input  logic signed [REF_W-1:0] ref_i [NLEG],
    input  ctrl_t                   ctrl_i,
    output logic signed [REF_W+1:0] adj_o [NLEG]
);
    localparam int SW = REF_W + 2;
    localparam logic signed [SW-1:0] FS = SW'((1 << (REF_W - 1)) - 1);

    logic signed [SW-1:0] ext [NLEG];
    logic signed [SW-1:0] mx, mn, sum, off;

    always_comb begin
        for (int k = 0; k < NLEG; k++)
            ext[k] = {{2{ref_i[k][REF_W-1]}}, ref_i[k]};
        mx = ext[0];
        mn = ext[0];
        for (int k = 1; k < NLEG; k++) begin
            if (ext[k] > mx) mx = ext[k];
            if (ext[k] < mn) mn = ext[k];
        end
        sum = mx + mn;
        if (ctrl_i.mode == MD_TLV)
            off = ctrl_i.cos_pos ? (FS - mx) : (-FS - mn);
        else
            off = -(sum >>> 1);
    end

    always_comb begin
        for (int k = 0; k < NLEG; k++) begin
            logic signed [SW-1:0] raw;
            raw = ext[k] + off;
            if (raw > FS)       adj_o[k] = FS;
            else if (raw < -FS) adj_o[k] = -FS;
            else                adj_o[k] = raw;
        end
    end

endmodule

// File: rtl/npwm_legmap.sv
module npwm_legmap
    import npwm_pkg::*;
(
    input  ctrl_t           ctrl_i,
    output logic [NLEG-1:0] inv_o
);
    always_comb begin
        case (ctrl_i.mode)
            MD_AZS:  inv_o = azs_mask(ctrl_i.sector);
            MD_TLV:  inv_o = tlv_mask(ctrl_i.sector);
            default: inv_o = '0;
        endcase
    end
endmodule

// File: rtl/npwm_modulator.sv
module npwm_modulator
    import npwm_pkg::*;
#(
    parameter int REF_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NLEG*REF_W-1:0]   ref_flat_i,
    input  logic [1:0]              mode_i,
    input  logic [SEC_W-1:0]        sector_i,
    input  logic                    cos9_pos_i,
    output logic [NLEG-1:0]         gate_o,
    output logic [CM_W-1:0]         cm_o
);
    localparam int SW = REF_W + 2;

    logic signed [SW-1:0]    car;
    logic                    peak;
    logic signed [REF_W-1:0] ref_in [NLEG];
    logic signed [REF_W-1:0] ref_q  [NLEG];
    ctrl_t                   ctrl_q;
    logic signed [SW-1:0]    adj    [NLEG];
    logic signed [SW-1:0]    sel_car[NLEG];
    logic [NLEG-1:0]         inv, gate_d;

    npwm_carrier #(.REF_W(REF_W)) u_car (
        .clk(clk), .rst(rst), .car_o(car), .peak_o(peak)
    );

    // Capture everything once per period at the carrier peak.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NLEG; k++) ref_q[k] <= '0;
            ctrl_q <= '{mode: MD_CONV, sector: '0, cos_pos: 1'b0};
        end else if (peak) begin
            for (int k = 0; k < NLEG; k++) ref_q[k] <= ref_in[k];
            ctrl_q <= '{mode: mode_e'(mode_i), sector: sector_i, cos_pos: cos9_pos_i};
        end
    end

    npwm_offset #(.REF_W(REF_W)) u_off (
        .ref_i(ref_q), .ctrl_i(ctrl_q), .adj_o(adj)
    );

    npwm_legmap u_map (
        .ctrl_i(ctrl_q), .inv_o(inv)
    );

    for (genvar k = 0; k < NLEG; k++) begin : g_leg
        assign ref_in[k]  = ref_flat_i[k*REF_W +: REF_W];
        assign sel_car[k] = inv[k] ? -car : car;
        assign gate_d[k]  = (adj[k] >= sel_car[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) gate_o <= '0;
        else     gate_o <= gate_d;
    end

    always_comb begin
        cm_o = '0;
        for (int k = 0; k < NLEG; k++)
            cm_o = cm_o + CM_W'(gate_o[k]);
    end

    // R3
    hold_refs_chk: assert property (@(posedge clk) disable iff (rst)
        !peak |=> ($stable(ref_q[0]) && $stable(ref_q[8]) && $stable(ctrl_q)));

    // R4
    conv_uninv_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MD_CONV) |-> (inv == '0));

    // R5
    azs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MD_AZS && ctrl_q.sector < SEC_W'(NSECT)) |-> ($countones(inv) == 2));

    // R7
    tlv_split_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MD_TLV && ctrl_q.sector < SEC_W'(NSECT))
            |-> ($countones(inv) == 4 || $countones(inv) == 5));

endmodule

// File: tb/sim_npwm_modulator.sv
module sim_npwm_modulator;
    localparam int W          = 8;
    localparam int FS         = 127;
    localparam int PER        = 4 * FS;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [9*W-1:0] ref_flat = '0;
    logic [1:0]     mode = 2'd0;
    logic [4:0]     sector = 5'd0;
    logic           cpos = 1'b0;
    logic [8:0]     gate;
    logic [3:0]     cm;

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit    chk_on = 1'b0;

    npwm_modulator #(.REF_W(W)) u0 (
        .clk(clk), .rst(rst), .ref_flat_i(ref_flat), .mode_i(mode),
        .sector_i(sector), .cos9_pos_i(cpos), .gate_o(gate), .cm_o(cm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench model state
    int         m_car, m_up, m_mode, m_sec;
    int         m_ref [9];
    bit         m_cpos;
    logic [8:0] m_gate;

    function automatic int leg_val(input logic [9*W-1:0] f, input int k);
        logic signed [W-1:0] v;
        v = f[k*W +: W];
        return int'(v);
    endfunction

    function automatic logic [8:0] f_exp(input int r[9], input int md, input int sec,
                                         input bit cp, input int car);
        int mx, mn, off, a, c, d;
        logic [8:0] g, inv;
        mx = r[0]; mn = r[0];
        for (int k = 1; k < 9; k++) begin
            if (r[k] > mx) mx = r[k];
            if (r[k] < mn) mn = r[k];
        end
        if (md == 2) off = cp ? (FS - mx) : (-FS - mn);
        else         off = -((mx + mn) >>> 1);
        inv = '0;
        if (sec < 18) begin
            for (int k = 0; k < 9; k++) begin
                d = (((sec - 2 * k) % 18) + 18) % 18;
                if (md == 1)      inv[k] = (d == 17 || d == 0 || d == 8 || d == 9);
                else if (md == 2) inv[k] = (d >= 9);
            end
        end
        for (int k = 0; k < 9; k++) begin
            a = r[k] + off;
            if (a > FS)  a = FS;
            if (a < -FS) a = -FS;
            c = inv[k] ? -car : car;
            g[k] = (a >= c);
        end
        return g;
    endfunction

    function automatic int ones(input logic [8:0] v);
        int n;
        n = 0;
        for (int k = 0; k < 9; k++) n += int'(v[k]);
        return n;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_car = -FS; m_up = 1; m_mode = 0; m_sec = 0; m_cpos = 1'b0; m_gate = '0;
            for (int k = 0; k < 9; k++) m_ref[k] = 0;
        end else begin
            m_gate = f_exp(m_ref, m_mode, m_sec, m_cpos, m_car);
            if (m_car == FS) begin
                for (int k = 0; k < 9; k++) m_ref[k] = leg_val(ref_flat, k);
                m_mode = int'(mode); m_sec = int'(sector); m_cpos = cpos;
            end
            if (m_up == 1) begin m_car++; if (m_car == FS) m_up = 0; end
            else           begin m_car--; if (m_car == -FS) m_up = 1; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(tag, int'(gate), int'(m_gate));
            check("R9", int'(cm), ones(gate));
        end
    end

    task automatic rand_refs();
        for (int k = 0; k < 9; k++) ref_flat[k*W +: W] = W'($urandom_range(255));
    endtask

    task automatic run(input int md, input int sec, input bit cp, input int cycles);
        @(negedge clk);
        rand_refs();
        mode = 2'(md); sector = 5'(sec); cpos = cp;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        int hi;
        void'($urandom(32'd8191));
        repeat (3) @(negedge clk);
        check("R1", int'(gate), 0);
        check("R1", int'(cm), 0);
        rst = 1'b0;
        chk_on = 1'b1;

        // R2 / R11: zero references, count high time of leg 0
        tag = "R2";
        repeat (2 * PER) @(negedge clk);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            hi += int'(gate[0]);
        end
        check("R2", hi, 2 * FS + 1);

        tag = "R4";
        for (int i = 0; i < 6; i++) run(0, int'($urandom_range(17)), 1'b0, PER);

        tag = "R5";
        for (int s = 0; s < 18; s++) run(1, s, 1'b0, PER);
        run(1, 18, 1'b0, PER);
        run(1, 31, 1'b0, PER);

        tag = "R6";
        run(2, 4, 1'b0, PER); run(2, 4, 1'b1, PER);
        run(2, 11, 1'b0, PER); run(2, 11, 1'b1, PER);

        tag = "R7";
        for (int s = 0; s < 18; s++) run(2, s, s[0], PER);
        run(2, 25, 1'b1, PER);

        // R3: inputs move mid-period; only peak captures count
        tag = "R3";
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rand_refs();
            mode = 2'($urandom_range(3)); sector = 5'($urandom_range(17));
            cpos = 1'($urandom_range(1));
            repeat (36) @(negedge clk);
        end

        // R8: extreme references drive the sum past the rails
        tag = "R8";
        @(negedge clk);
        for (int k = 0; k < 9; k++) ref_flat[k*W +: W] = (k == 3) ? 8'h80 : 8'h7F;
        mode = 2'd0; sector = 5'd2; repeat (2 * PER) @(negedge clk);
        mode = 2'd2; cpos = 1'b0;   repeat (2 * PER) @(negedge clk);
        for (int k = 0; k < 9; k++) ref_flat[k*W +: W] = (k == 7) ? 8'h7F : 8'h80;
        cpos = 1'b1;                repeat (2 * PER) @(negedge clk);

        tag = "R10";
        for (int i = 0; i < 3; i++) run(3, int'($urandom_range(17)), 1'b1, PER);

        chk_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule